// File: doc/BRIEF.md
# Destination Address Filter with Station Table

This block decides, for each received frame, whether the frame is kept or dropped. It looks only at the 48-bit destination address. Three receive-control inputs can accept whole classes of traffic: all unicast (promiscuous), all group addresses, and the all-ones broadcast address. A table of 16 station addresses, each gated by its own bit in an enable mask, accepts individual addresses. The verdict is registered, so it appears one clock after the address is presented. It carries an accept bit, a group or broadcast class flag, and the index of the table entry that matched.

The address is taken in wire order, with the first byte in bits 47:40. The individual/group bit is therefore bit 40.

The table is filled by a short load sequence. A start pulse gives the number of entries to write, from 0 to 31. Each following data beat writes the next entry. Once the count is used up, the next beat supplies the enable mask and ends the sequence. A done flag then stays set. While a hold-in-reset input is high, any table entry can be read back through a pointer port.

Top module: `da_filter`

## Requirements
- R1: After reset every table entry reads as zero and the enable mask is zero. `ld_busy`, `ld_done` and `res_valid` are low.
- R2: The verdict is registered. `res_valid` in a cycle equals `fr_valid` of the previous cycle. When `res_valid` is low, every other `res_*` output is zero.
- R3: First priority: if `cfg_promisc` is high and bit 40 of the address is 0 (unicast), the frame is accepted with no class flag and `res_cam_hit` low.
- R4: Second priority: if `cfg_all_mcast` is high and bit 40 is 1, the frame is accepted with `res_mcast` high. This applies to the broadcast address too.
- R5: Third priority: if `cfg_bcast` is high and all 48 address bits are 1, the frame is accepted with `res_bcast` high.
- R6: Fourth priority: the frame is accepted with `res_cam_hit` high if an entry whose mask bit i is set equals the address in all 48 bits. `res_idx` gives the lowest such index. `res_idx` is zero whenever `res_cam_hit` is low.
- R7: A frame not accepted by R3 to R6 gets `res_accept` low and all class flags low. At most one of `res_mcast`, `res_bcast` and `res_cam_hit` is ever high.
- R8: `ld_start` while not busy captures the 5-bit `ld_count`, sets `ld_busy` and clears `ld_done` on the next clock. `ld_start` while busy is ignored.
- R9: While busy with a nonzero remaining count, each `ld_wr_valid` beat writes `ld_wr_data` into entry (number of entries already written in this sequence) mod 16 and lowers the count by one. A count above 16 wraps onto entry 0.
- R10: While busy with zero remaining count, an `ld_wr_valid` beat loads the mask from `ld_wr_data[15:0]`. On that clock `ld_busy` falls and `ld_done` rises. `ld_done` stays high until the next accepted `ld_start`. `ld_wr_valid` while not busy changes nothing.
- R11: `rd_data` shows entry `rd_ptr` while `hold_rst` is high, and zero otherwise. It is combinational from the table state.
- R12: A frame presented in the same cycle as a table or mask write is judged on the contents before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_promisc | input | 1 | Accept every unicast address |
| cfg_all_mcast | input | 1 | Accept every group address |
| cfg_bcast | input | 1 | Accept the broadcast address |
| fr_valid | input | 1 | Destination address present this cycle |
| fr_da | input | 48 | Destination address, first byte in 47:40 |
| res_valid | output | 1 | Verdict valid |
| res_accept | output | 1 | Frame accepted |
| res_mcast | output | 1 | Accepted as group traffic |
| res_bcast | output | 1 | Accepted as broadcast |
| res_cam_hit | output | 1 | Accepted by a table entry |
| res_idx | output | 4 | Index of the matching entry |
| ld_start | input | 1 | Begin a load sequence |
| ld_count | input | 5 | Number of entries to load |
| ld_wr_valid | input | 1 | Load data beat |
| ld_wr_data | input | 48 | Entry value, or mask in 15:0 |
| ld_busy | output | 1 | Load sequence in progress |
| ld_done | output | 1 | Last load sequence finished |
| hold_rst | input | 1 | Hold-in-reset mode, enables readback |
| rd_ptr | input | 4 | Readback entry index |
| rd_data | output | 48 | Readback entry value |

## Verification
The assertions check on every cycle the properties that hold whatever the table contains:
- the one-cycle verdict timing and the zero outputs when no frame was presented;
- that class flags exclude each other;
- the promiscuous-unicast, all-group and broadcast outcomes;
- the start and finish handshake of the load sequence;
- the zero readback outside hold mode.

Only the bench's reference model, compared on every clock, can show the rest:
- which table entry wins when duplicates are enabled;
- that disabled entries are blind;
- where a count above 16 wraps;
- that a start during a load is ignored;
- that a frame coinciding with a write sees the old contents.

// File: rtl/da_filter_pkg.sv
`timescale 1ns/1ps
package da_filter_pkg;
    localparam int unsigned DA_W    = 48;
    localparam int unsigned ENTRIES = 16;
    localparam int unsigned CNT_W   = 5;

    // Which rule decided a verdict, in falling priority.
    typedef enum logic [2:0] {
        PATH_NONE    = 3'd0,
        PATH_PROMISC = 3'd1,
        PATH_GROUP   = 3'd2,
        PATH_BCAST   = 3'd3,
        PATH_TABLE   = 3'd4
    } path_e;
endpackage

// File: rtl/da_filter_cam.sv
`timescale 1ns/1ps
// Station address table plus enable mask.
module da_filter_cam #(
    parameter int unsigned ENTRIES = da_filter_pkg::ENTRIES,
    parameter int unsigned DA_W    = da_filter_pkg::DA_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ent_we,
    input  logic [IDX_W-1:0]    ent_idx,
    input  logic [DA_W-1:0]     ent_data,
    input  logic                mask_we,
    input  logic [ENTRIES-1:0]  mask_data,
    output logic [DA_W-1:0]     ent_o [ENTRIES],
    output logic [ENTRIES-1:0]  mask_o
);
    logic [DA_W-1:0]    ent_d [ENTRIES];
    logic [DA_W-1:0]    ent_q [ENTRIES];
    logic [ENTRIES-1:0] mask_d, mask_q;

    always_comb begin
        ent_d  = ent_q;
        mask_d = mask_q;
        if (ent_we) begin
            ent_d[ent_idx] = ent_data;
        end
        if (mask_we) begin
            mask_d = mask_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                ent_q[i] <= '0;
            end
            mask_q <= '0;
        end else begin
            ent_q  <= ent_d;
            mask_q <= mask_d;
        end
    end

    assign ent_o  = ent_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/da_filter_match.sv
`timescale 1ns/1ps
// Parallel compare of the key against every enabled entry, lowest index wins.
module da_filter_match #(
    parameter int unsigned ENTRIES = da_filter_pkg::ENTRIES,
    parameter int unsigned DA_W    = da_filter_pkg::DA_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [DA_W-1:0]     ent [ENTRIES],
    input  logic [ENTRIES-1:0]  mask,
    input  logic [DA_W-1:0]     key,
    output logic                hit,
    output logic [IDX_W-1:0]    hit_idx
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_cmp
        assign hit_vec[g] = mask[g] && (ent[g] == key);
    end

    always_comb begin
        hit     = |hit_vec;
        hit_idx = '0;
        for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/da_filter_decide.sv
`timescale 1ns/1ps
// Fixed-priority verdict: promiscuous unicast, group, broadcast, table.
module da_filter_decide #(
    parameter int unsigned ENTRIES = da_filter_pkg::ENTRIES,
    parameter int unsigned DA_W    = da_filter_pkg::DA_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [DA_W-1:0]   key,
    input  logic              promisc,
    input  logic              all_grp,
    input  logic              bcast_en,
    input  logic              tbl_hit,
    input  logic [IDX_W-1:0]  tbl_idx,
    output logic              accept,
    output logic              grp_flag,
    output logic              bc_flag,
    output logic              hit_flag,
    output logic [IDX_W-1:0]  hit_idx
);
    import da_filter_pkg::*;

    // Least significant bit of the first byte on the wire.
    localparam int unsigned GRP_BIT = DA_W - 8;

    path_e path;
    logic  is_group;
    logic  is_bcast;

    assign is_group = key[GRP_BIT];
    assign is_bcast = &key;

    always_comb begin
        if (promisc && !is_group) begin
            path = PATH_PROMISC;
        end else if (all_grp && is_group) begin
            path = PATH_GROUP;
        end else if (bcast_en && is_bcast) begin
            path = PATH_BCAST;
        end else if (tbl_hit) begin
            path = PATH_TABLE;
        end else begin
            path = PATH_NONE;
        end
    end

    always_comb begin
        accept   = (path != PATH_NONE);
        grp_flag = (path == PATH_GROUP);
        bc_flag  = (path == PATH_BCAST);
        hit_flag = (path == PATH_TABLE);
        hit_idx  = (path == PATH_TABLE) ? tbl_idx : '0;
    end
endmodule

// File: rtl/da_filter_load.sv
`timescale 1ns/1ps
// Load sequencer: N entry beats, then one mask beat.
module da_filter_load #(
    parameter int unsigned ENTRIES = da_filter_pkg::ENTRIES,
    parameter int unsigned CNT_W   = da_filter_pkg::CNT_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic              wr_valid,
    output logic              ent_we,
    output logic [IDX_W-1:0]  ent_idx,
    output logic              mask_we,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] left;
        logic [IDX_W-1:0] idx;
    } ld_state_t;

    ld_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        ent_we  = 1'b0;
        mask_we = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.done = 1'b0;
                s_d.left = count;
                s_d.idx  = '0;
            end
        end else if (wr_valid) begin
            if (s_q.left != '0) begin
                ent_we   = 1'b1;
                s_d.idx  = s_q.idx + IDX_W'(1);
                s_d.left = s_q.left - CNT_W'(1);
            end else begin
                mask_we  = 1'b1;
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ent_idx = s_q.idx;
    assign busy    = s_q.busy;
    assign done    = s_q.done;
endmodule

// File: rtl/da_filter.sv
`timescale 1ns/1ps
module da_filter #(
    parameter int unsigned ENTRIES = da_filter_pkg::ENTRIES,
    parameter int unsigned DA_W    = da_filter_pkg::DA_W,
    parameter int unsigned CNT_W   = da_filter_pkg::CNT_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_promisc,
    input  logic              cfg_all_mcast,
    input  logic              cfg_bcast,
    input  logic              fr_valid,
    input  logic [DA_W-1:0]   fr_da,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_mcast,
    output logic              res_bcast,
    output logic              res_cam_hit,
    output logic [IDX_W-1:0]  res_idx,
    input  logic              ld_start,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic              ld_wr_valid,
    input  logic [DA_W-1:0]   ld_wr_data,
    output logic              ld_busy,
    output logic              ld_done,
    input  logic              hold_rst,
    input  logic [IDX_W-1:0]  rd_ptr,
    output logic [DA_W-1:0]   rd_data
);
    typedef struct packed {
        logic             valid;
        logic             accept;
        logic             grp;
        logic             bc;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } res_t;

    logic [DA_W-1:0]    ent [ENTRIES];
    logic [ENTRIES-1:0] mask;
    logic               ent_we, mask_we;
    logic [IDX_W-1:0]   ent_idx;
    logic               tbl_hit;
    logic [IDX_W-1:0]   tbl_idx;
    logic               v_accept, v_grp, v_bc, v_hit;
    logic [IDX_W-1:0]   v_idx;
    res_t               res_d, res_q;

    da_filter_load #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ld_start),
        .count    (ld_count),
        .wr_valid (ld_wr_valid),
        .ent_we   (ent_we),
        .ent_idx  (ent_idx),
        .mask_we  (mask_we),
        .busy     (ld_busy),
        .done     (ld_done)
    );

    da_filter_cam #(.ENTRIES(ENTRIES), .DA_W(DA_W)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_we    (ent_we),
        .ent_idx   (ent_idx),
        .ent_data  (ld_wr_data),
        .mask_we   (mask_we),
        .mask_data (ld_wr_data[ENTRIES-1:0]),
        .ent_o     (ent),
        .mask_o    (mask)
    );

    da_filter_match #(.ENTRIES(ENTRIES), .DA_W(DA_W)) u_match (
        .ent     (ent),
        .mask    (mask),
        .key     (fr_da),
        .hit     (tbl_hit),
        .hit_idx (tbl_idx)
    );

    da_filter_decide #(.ENTRIES(ENTRIES), .DA_W(DA_W)) u_decide (
        .key      (fr_da),
        .promisc  (cfg_promisc),
        .all_grp  (cfg_all_mcast),
        .bcast_en (cfg_bcast),
        .tbl_hit  (tbl_hit),
        .tbl_idx  (tbl_idx),
        .accept   (v_accept),
        .grp_flag (v_grp),
        .bc_flag  (v_bc),
        .hit_flag (v_hit),
        .hit_idx  (v_idx)
    );

    always_comb begin
        res_d = '0;
        if (fr_valid) begin
            res_d.valid  = 1'b1;
            res_d.accept = v_accept;
            res_d.grp    = v_grp;
            res_d.bc     = v_bc;
            res_d.hit    = v_hit;
            res_d.idx    = v_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid   = res_q.valid;
    assign res_accept  = res_q.accept;
    assign res_mcast   = res_q.grp;
    assign res_bcast   = res_q.bc;
    assign res_cam_hit = res_q.hit;
    assign res_idx     = res_q.idx;

    assign rd_data = hold_rst ? ent[rd_ptr] : '0;
endmodule

// File: rtl/da_filter_chk.sv
`timescale 1ns/1ps
module da_filter_chk #(
    parameter int unsigned DA_W   = da_filter_pkg::DA_W,
    parameter int unsigned IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_promisc,
    input logic              cfg_all_mcast,
    input logic              cfg_bcast,
    input logic              fr_valid,
    input logic [DA_W-1:0]   fr_da,
    input logic              res_valid,
    input logic              res_accept,
    input logic              res_mcast,
    input logic              res_bcast,
    input logic              res_cam_hit,
    input logic [IDX_W-1:0]  res_idx,
    input logic              ld_start,
    input logic              ld_busy,
    input logic              ld_done,
    input logic              hold_rst,
    input logic [DA_W-1:0]   rd_data
);
    localparam int unsigned GRP_BIT = DA_W - 8;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fr_valid |=> res_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fr_valid |=> (!res_valid && !res_accept && !res_mcast && !res_bcast && !res_cam_hit));

    assert_promisc_unicast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && cfg_promisc && !fr_da[GRP_BIT])
        |=> (res_accept && !res_mcast && !res_bcast && !res_cam_hit));

    assert_all_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && cfg_all_mcast && fr_da[GRP_BIT]) |=> (res_accept && res_mcast));

    assert_broadcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && cfg_bcast && !cfg_all_mcast && (&fr_da)) |=> (res_accept && res_bcast));

    assert_idx_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_cam_hit |-> (res_idx == '0));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({res_mcast, res_bcast, res_cam_hit}) <= 1);

    assert_reject_flagless_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !res_accept |-> (!res_mcast && !res_bcast && !res_cam_hit));

    assert_start_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_start && !ld_busy) |=> (ld_busy && !ld_done));

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ld_done) |-> $fell(ld_busy));

    assert_readback_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_rst |-> (rd_data == '0));
endmodule

bind da_filter da_filter_chk #(.DA_W(DA_W), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_promisc   (cfg_promisc),
    .cfg_all_mcast (cfg_all_mcast),
    .cfg_bcast     (cfg_bcast),
    .fr_valid      (fr_valid),
    .fr_da         (fr_da),
    .res_valid     (res_valid),
    .res_accept    (res_accept),
    .res_mcast     (res_mcast),
    .res_bcast     (res_bcast),
    .res_cam_hit   (res_cam_hit),
    .res_idx       (res_idx),
    .ld_start      (ld_start),
    .ld_busy       (ld_busy),
    .ld_done       (ld_done),
    .hold_rst      (hold_rst),
    .rd_data       (rd_data)
);

// File: tb/da_filter_bench.sv
`timescale 1ns/1ps
module da_filter_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        cfg_promisc, cfg_all_mcast, cfg_bcast;
    logic        fr_valid;
    logic [47:0] fr_da;
    logic        res_valid, res_accept, res_mcast, res_bcast, res_cam_hit;
    logic [3:0]  res_idx;
    logic        ld_start;
    logic [4:0]  ld_count;
    logic        ld_wr_valid;
    logic [47:0] ld_wr_data;
    logic        ld_busy, ld_done;
    logic        hold_rst;
    logic [3:0]  rd_ptr;
    logic [47:0] rd_data;

    da_filter u_da_filter (.*);

    int total = 0;
    int bad   = 0;

    // Reference model state
    logic [47:0] m_tab [16];
    logic [15:0] m_mask;
    bit          m_busy, m_done;
    int          m_left, m_wr;
    bit          e_valid, e_acc, e_grp, e_bc, e_hit;
    int          e_idx;

    localparam logic [47:0] A0 = 48'h02_11_22_33_44_55;
    localparam logic [47:0] A1 = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [47:0] A2 = 48'h02_66_77_88_99_AA;
    localparam logic [47:0] UNI = 48'h04_01_02_03_04_05;
    localparam logic [47:0] GRP = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        fr_valid = 0; ld_start = 0; ld_wr_valid = 0;
    endtask

    task automatic model_step();
        e_valid = fr_valid; e_acc = 0; e_grp = 0; e_bc = 0; e_hit = 0; e_idx = 0;
        if (fr_valid) begin
            if (cfg_promisc && fr_da[40] == 1'b0) e_acc = 1;
            else if (cfg_all_mcast && fr_da[40] == 1'b1) begin e_acc = 1; e_grp = 1; end
            else if (cfg_bcast && fr_da == BC) begin e_acc = 1; e_bc = 1; end
            else begin
                for (int i = 0; i < 16; i++) begin
                    if (!e_hit && m_mask[i] && m_tab[i] == fr_da) begin
                        e_acc = 1; e_hit = 1; e_idx = i;
                    end
                end
            end
        end
        if (!m_busy) begin
            if (ld_start) begin m_busy = 1; m_done = 0; m_left = ld_count; m_wr = 0; end
        end else if (ld_wr_valid) begin
            if (m_left != 0) begin m_tab[m_wr % 16] = ld_wr_data; m_wr++; m_left--; end
            else begin m_mask = ld_wr_data[15:0]; m_busy = 0; m_done = 1; end
        end
    endtask

    task automatic compare_all();
        chk("R2 res_valid",    res_valid,   e_valid);
        chk("R7 res_accept",   res_accept,  e_acc);
        chk("R4 res_mcast",    res_mcast,   e_grp);
        chk("R5 res_bcast",    res_bcast,   e_bc);
        chk("R6 res_cam_hit",  res_cam_hit, e_hit);
        chk("R6 res_idx",      res_idx,     e_idx);
        chk("R8 ld_busy",      ld_busy,     m_busy);
        chk("R10 ld_done",     ld_done,     m_done);
        chk("R11 rd_data",     rd_data,     hold_rst ? m_tab[rd_ptr] : 48'h0);
    endtask

    // inputs are set at a negedge before calling
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        quiet();
    endtask

    task automatic look(input logic [47:0] da);
        fr_valid = 1; fr_da = da; step();
    endtask

    task automatic set_cfg(input bit p, input bit g, input bit b);
        cfg_promisc = p; cfg_all_mcast = g; cfg_bcast = b;
    endtask

    initial begin
        rst_n = 0; quiet(); set_cfg(0, 0, 0);
        fr_da = '0; ld_count = '0; ld_wr_data = '0; hold_rst = 1; rd_ptr = 4'd5;
        for (int i = 0; i < 16; i++) m_tab[i] = '0;
        m_mask = '0; m_busy = 0; m_done = 0; m_left = 0; m_wr = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 res_valid", res_valid, 0);
        chk("R1 ld_busy", ld_busy, 0);
        chk("R1 ld_done", ld_done, 0);
        chk("R1 entry zero", rd_data, 48'h0);
        rst_n = 1;
        @(negedge clk);
        e_valid = 0; e_acc = 0; e_grp = 0; e_bc = 0; e_hit = 0; e_idx = 0;
        // R1 mask zero: address equal to reset entries rejected
        look(48'h0);
        chk("R1 mask zero rejects", res_accept, 0);

        // Load A0, A1, A2, A1 with mask 0b1011
        ld_start = 1; ld_count = 5'd4; step();
        ld_wr_valid = 1; ld_wr_data = A0; fr_valid = 1; fr_da = A0; step();
        chk("R12 lookup sees old table", res_accept, 0);
        ld_wr_valid = 1; ld_wr_data = A1; step();
        ld_wr_valid = 1; ld_wr_data = A2; step();
        ld_wr_valid = 1; ld_wr_data = A1; step();
        ld_wr_valid = 1; ld_wr_data = 48'h000B; step();
        chk("R10 done after mask", ld_done, 1);
        look(A0); chk("R6 entry 0 hit", res_cam_hit, 1);
        look(A1); chk("R6 lowest of duplicates", res_idx, 1);
        look(A2); chk("R6 disabled entry blind", res_accept, 0);
        look(UNI); chk("R7 unknown rejected", res_accept, 0);

        set_cfg(1, 0, 0);
        look(UNI); chk("R3 promisc unicast", res_accept, 1);
        look(A1);  chk("R3 promisc before table", res_cam_hit, 0);
        look(GRP); chk("R3 promisc ignores group", res_accept, 0);
        set_cfg(0, 1, 1);
        look(GRP); chk("R4 group accepted", res_mcast, 1);
        look(BC);  chk("R4 group over broadcast", res_mcast, 1);
        set_cfg(0, 0, 1);
        look(BC);  chk("R5 broadcast flag", res_bcast, 1);
        set_cfg(0, 0, 0);
        look(BC);  chk("R7 broadcast off", res_accept, 0);

        hold_rst = 1; rd_ptr = 4'd1; step();
        chk("R11 readback entry 1", rd_data, A1);
        hold_rst = 0; step();
        chk("R11 readback gated", rd_data, 48'h0);

        // Start ignored while busy
        ld_start = 1; ld_count = 5'd2; step();
        ld_start = 1; ld_count = 5'd7; step();
        ld_wr_valid = 1; ld_wr_data = 48'h02_00_00_00_00_07; step();
        ld_wr_valid = 1; ld_wr_data = 48'h02_00_00_00_00_08; step();
        ld_wr_valid = 1; ld_wr_data = 48'h0003; step();
        chk("R8 second start ignored", ld_done, 1);
        // write while idle ignored
        ld_wr_valid = 1; ld_wr_data = 48'h02_DE_AD_00_00_00; step();
        hold_rst = 1; rd_ptr = 4'd2; step();
        chk("R10 idle beat ignored", rd_data, A2);

        // Count zero: next beat is the mask
        ld_start = 1; ld_count = 5'd0; step();
        ld_wr_valid = 1; ld_wr_data = 48'h0001; step();
        chk("R10 zero count mask only", ld_busy, 0);

        // Count 18 wraps
        ld_start = 1; ld_count = 5'd18; step();
        for (int i = 0; i < 18; i++) begin
            ld_wr_valid = 1; ld_wr_data = 48'h0200_0000_0100 + 48'(i); step();
        end
        ld_wr_valid = 1; ld_wr_data = 48'hFFFF; step();
        rd_ptr = 4'd0; step();
        chk("R9 wrap onto entry 0", rd_data, 48'h0200_0000_0110);
        rd_ptr = 4'd15; step();
        chk("R9 entry 15", rd_data, 48'h0200_0000_010F);

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            if (c % 50 == 0) set_cfg($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
            fr_valid = $urandom_range(0, 1);
            case ($urandom_range(0, 3))
                0: fr_da = m_tab[$urandom_range(0, 15)];
                1: fr_da = BC;
                2: fr_da = {$urandom, 16'h0} ^ 48'($urandom);
                default: fr_da = {8'($urandom_range(0, 1)), 40'h00_0000_0001 + 40'($urandom_range(0, 3))};
            endcase
            ld_start = ($urandom_range(0, 39) == 0);
            ld_count = 5'($urandom_range(0, 19));
            ld_wr_valid = $urandom_range(0, 1);
            ld_wr_data = {16'($urandom), $urandom};
            hold_rst = $urandom_range(0, 1);
            rd_ptr = 4'($urandom_range(0, 15));
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule